// File: doc/BRIEF.md
# P-Persistent CSMA Transmit Keying Controller

This block decides when a queued frame may be put on a shared half-duplex radio channel and sequences the radio around each transmission. While the channel is busy it holds off. Once the channel is clear it rolls a persistence dice against a free-running random byte. When it wins, it turns the receiver off, raises RTS, waits for the keying delay and then enables the transmitter. After a programmable TX delay it hands data bytes to an external serializer, one per request. At the end of a frame it lets the serializer underrun so that the checksum and closing flags go out. If another frame is already queued, it chains that frame without contending again. If not, it releases the radio.

All delays are counted in ticks of an external strobe, which is nominally 10 ms. The keying controller runs as one state machine: `ST_IDLE`, `ST_DEFER`, `ST_KEYUP`, `ST_TXDLY`, `ST_SEND`, `ST_TAIL` and `ST_ENDDLY`. Its transitions are as follows:
- IDLE→DEFER when a frame is pending and no retry wait is running.
- DEFER→KEYUP when contention is won.
- KEYUP→TXDLY when the keying wait expires.
- TXDLY→SEND when the TX delay expires, which also starts a frame.
- SEND→TAIL on a byte request after the last byte.
- SEND→IDLE on an unexpected underrun, which drops the frame.
- TAIL→ENDDLY on the next byte request.
- ENDDLY→SEND when the end delay expires and a frame is pending (chained frame).
- ENDDLY→IDLE when the end delay expires and nothing is pending.

Two independent tick timers are used: one for the transmit path and one for the receiver-enable (squelch) delay. Each timer fires once, on the tick that brings it to zero. A delay parameter of 0 acts as 1 tick.

Top module: `csma_key_ctrl`

## Requirements
- R1: After reset, rts, tx_en, rx_en, frame_start, byte_fetch, frame_done and frame_drop are 0, and both event counters are 0.
- R2: While the machine is in IDLE or DEFER with the receiver off, a squelch countdown of p_squelch ticks runs. rx_en rises on the tick that ends it and not before.
- R3: If carrier_det is 1 when contention is evaluated in DEFER, defer_cnt increments, the radio stays unkeyed and the next evaluation happens only after RECHECK_TICKS (default 10) further ticks.
- R4: If carrier_det is 0 and p_persist <= rand_byte (unsigned), backoff_cnt increments and the next evaluation happens after p_slottime ticks. If p_persist > rand_byte, the block keys up.
- R5: On keying, rts goes to 1 and rx_en goes to 0 with tx_en still 0. tx_en rises on the KEYUP_TICKS-th (default 10) tick. After p_txdelay more ticks, frame_start and byte_fetch pulse together for one cycle.
- R6: frame_len is sampled at frame_start, and a value of 0 counts as 1. Each frame yields exactly frame_len byte_fetch pulses: one at frame_start and one per byte_req while bytes remain. A byte_req after the last byte fetches nothing.
- R7: An underrun after the last byte has been supplied is ignored. The next byte_req starts an end delay of p_enddelay ticks, and frame_done pulses when that delay ends.
- R8: If frame_pending is 1 when the end delay ends, frame_start and byte_fetch pulse at once. rts and tx_en stay 1, and neither counter changes, whatever carrier_det is.
- R9: If frame_pending is 0 when the end delay ends, rts and tx_en fall to 0 and rx_en rises to 1 in the same cycle.
- R10: An underrun in SEND while bytes remain pulses frame_drop and sets rts=0, tx_en=0 and rx_en=1. A pending frame is re-contended only after p_slottime ticks.
- R11: An underrun outside SEND and the tail is ignored: no frame_drop, and no change to the keying outputs.
- R12: defer_cnt and backoff_cnt saturate at all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle strobe, one per time unit (10 ms) |
| frame_pending | input | 1 | A frame is queued for transmission |
| frame_len | input | LEN_W | Byte count of the queued frame |
| carrier_det | input | 1 | Channel busy |
| rand_byte | input | 8 | Free-running pseudo-random byte |
| p_persist | input | 8 | Persistence threshold |
| p_txdelay | input | PARAM_W | TX delay in ticks |
| p_slottime | input | PARAM_W | Slot time in ticks |
| p_squelch | input | PARAM_W | Receiver re-enable delay in ticks |
| p_enddelay | input | PARAM_W | End-of-frame flag tail in ticks |
| byte_req | input | 1 | Serializer requests the next byte |
| underrun | input | 1 | Serializer ran out of data |
| rts | output | 1 | Request to send (key the radio) |
| tx_en | output | 1 | Transmitter and checksum generation enabled |
| rx_en | output | 1 | Receiver enabled |
| frame_start | output | 1 | Pulse: take a frame, reset the checksum, clear the underrun latch |
| byte_fetch | output | 1 | Pulse: load the next data byte into the serializer |
| frame_done | output | 1 | Pulse: frame completed |
| frame_drop | output | 1 | Pulse: frame discarded on underrun |
| defer_cnt | output | CNT_W | Saturating carrier-deferral count |
| backoff_cnt | output | CNT_W | Saturating persistence backoff count |

## Verification
A wrong state in this machine shows up as a keying output that moves on the wrong tick. For example, tx_en may rise one tick early or late, or rts may drop between chained frames. It can also show up as a byte_fetch count that differs from frame_len, or as a counter that moves when it should not. All of these are visible at the ports within one cycle of the tick or request that should have caused the change. The bench therefore checks each output just after the exact tick edge, and also one tick before it.

// File: rtl/csma_key_pkg.sv
package csma_key_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_DEFER  = 3'd1,
        ST_KEYUP  = 3'd2,
        ST_TXDLY  = 3'd3,
        ST_SEND   = 3'd4,
        ST_TAIL   = 3'd5,
        ST_ENDDLY = 3'd6
    } key_state_e;
endpackage

// File: rtl/csma_tick_timer.sv
module csma_tick_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    input  logic         cancel,
    input  logic         tick,
    output logic         busy,
    output logic         fire
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cancel) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= (val == '0) ? ONE : val;
        end else if (tick && cnt != '0) begin
            cnt <= cnt - ONE;
        end
    end

    assign busy = (cnt != '0);
    assign fire = tick && (cnt == ONE);

    // Once fired and not reloaded, the timer is idle
    AST_TIMER_IDLE_AFTER_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        fire && !load && !cancel |=> !busy); // R3
    AST_TIMER_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick && !load && !cancel |=> $stable(cnt)); // R2
endmodule

// File: rtl/csma_sat_cnt.sv
module csma_sat_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (inc && cnt != TOP) begin
            cnt <= cnt + W'(1);
        end
    end

    AST_SAT_STAYS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        cnt == TOP |=> cnt == TOP); // R12
    AST_SAT_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(cnt)); // R12
endmodule

// File: rtl/csma_key_ctrl.sv
module csma_key_ctrl
    import csma_key_pkg::*;
#(
    parameter int PARAM_W       = 8,
    parameter int LEN_W         = 12,
    parameter int CNT_W         = 8,
    parameter int RECHECK_TICKS = 10,
    parameter int KEYUP_TICKS   = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               frame_pending,
    input  logic [LEN_W-1:0]   frame_len,
    input  logic               carrier_det,
    input  logic [7:0]         rand_byte,
    input  logic [7:0]         p_persist,
    input  logic [PARAM_W-1:0] p_txdelay,
    input  logic [PARAM_W-1:0] p_slottime,
    input  logic [PARAM_W-1:0] p_squelch,
    input  logic [PARAM_W-1:0] p_enddelay,
    input  logic               byte_req,
    input  logic               underrun,
    output logic               rts,
    output logic               tx_en,
    output logic               rx_en,
    output logic               frame_start,
    output logic               byte_fetch,
    output logic               frame_done,
    output logic               frame_drop,
    output logic [CNT_W-1:0]   defer_cnt,
    output logic [CNT_W-1:0]   backoff_cnt
);
    localparam logic [PARAM_W-1:0] RECHECK_V = PARAM_W'(RECHECK_TICKS);
    localparam logic [PARAM_W-1:0] KEYUP_V   = PARAM_W'(KEYUP_TICKS);

    key_state_e st, nxt;

    logic               tx_busy, tx_fire, sq_busy, sq_fire;
    logic               tld, sq_load;
    logic [PARAM_W-1:0] tval;
    logic               go_start, go_fetch, go_done, go_drop;
    logic               inc_def, inc_bo, key_on, tx_on, key_off;
    logic [LEN_W-1:0]   left;

    // ---------------- next-state and action decode ----------------
    always_comb begin
        nxt      = st;
        tld      = 1'b0;
        tval     = '0;
        go_start = 1'b0;
        go_fetch = 1'b0;
        go_done  = 1'b0;
        go_drop  = 1'b0;
        inc_def  = 1'b0;
        inc_bo   = 1'b0;
        key_on   = 1'b0;
        tx_on    = 1'b0;
        key_off  = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (frame_pending && !tx_busy) nxt = ST_DEFER;
            end
            ST_DEFER: begin
                if (!tx_busy) begin
                    if (carrier_det) begin
                        inc_def = 1'b1;
                        tld     = 1'b1;
                        tval    = RECHECK_V;
                    end else if (p_persist <= rand_byte) begin
                        inc_bo  = 1'b1;
                        tld     = 1'b1;
                        tval    = p_slottime;
                    end else begin
                        nxt     = ST_KEYUP;
                        tld     = 1'b1;
                        tval    = KEYUP_V;
                        key_on  = 1'b1;
                    end
                end
            end
            ST_KEYUP: begin
                if (tx_fire) begin
                    nxt   = ST_TXDLY;
                    tld   = 1'b1;
                    tval  = p_txdelay;
                    tx_on = 1'b1;
                end
            end
            ST_TXDLY: begin
                if (tx_fire) begin
                    nxt      = ST_SEND;
                    go_start = 1'b1;
                    go_fetch = 1'b1;
                end
            end
            ST_SEND: begin
                if (underrun) begin
                    nxt     = ST_IDLE;
                    go_drop = 1'b1;
                    key_off = 1'b1;
                    tld     = 1'b1;
                    tval    = p_slottime;
                end else if (byte_req) begin
                    if (left != '0) go_fetch = 1'b1;
                    else            nxt      = ST_TAIL;
                end
            end
            ST_TAIL: begin
                if (byte_req) begin
                    nxt  = ST_ENDDLY;
                    tld  = 1'b1;
                    tval = p_enddelay;
                end
            end
            ST_ENDDLY: begin
                if (tx_fire) begin
                    go_done = 1'b1;
                    if (frame_pending) begin
                        nxt      = ST_SEND;
                        go_start = 1'b1;
                        go_fetch = 1'b1;
                    end else begin
                        nxt     = ST_IDLE;
                        key_off = 1'b1;
                    end
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    assign sq_load = ((st == ST_IDLE) || (st == ST_DEFER)) && !rx_en && !sq_busy;

    // ---------------- state register and byte budget ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= ST_IDLE;
            left <= '0;
        end else begin
            st <= nxt;
            if (go_start)      left <= (frame_len == '0) ? '0 : frame_len - LEN_W'(1);
            else if (go_fetch) left <= left - LEN_W'(1);
        end
    end

    // ---------------- registered outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rts         <= 1'b0;
            tx_en       <= 1'b0;
            rx_en       <= 1'b0;
            frame_start <= 1'b0;
            byte_fetch  <= 1'b0;
            frame_done  <= 1'b0;
            frame_drop  <= 1'b0;
        end else begin
            frame_start <= go_start;
            byte_fetch  <= go_fetch;
            frame_done  <= go_done;
            frame_drop  <= go_drop;
            if (sq_fire) rx_en <= 1'b1;
            if (key_on) begin
                rts   <= 1'b1;
                rx_en <= 1'b0;
            end
            if (tx_on) tx_en <= 1'b1;
            if (key_off) begin
                rts   <= 1'b0;
                tx_en <= 1'b0;
                rx_en <= 1'b1;
            end
        end
    end

    // ---------------- timers and counters ----------------
    csma_tick_timer #(.W(PARAM_W)) u_tx_tmr (
        .clk(clk), .rst_n(rst_n), .load(tld), .val(tval), .cancel(1'b0),
        .tick(tick), .busy(tx_busy), .fire(tx_fire)
    );

    csma_tick_timer #(.W(PARAM_W)) u_sq_tmr (
        .clk(clk), .rst_n(rst_n), .load(sq_load), .val(p_squelch), .cancel(key_on),
        .tick(tick), .busy(sq_busy), .fire(sq_fire)
    );

    csma_sat_cnt #(.W(CNT_W)) u_def_cnt (
        .clk(clk), .rst_n(rst_n), .inc(inc_def), .cnt(defer_cnt)
    );

    csma_sat_cnt #(.W(CNT_W)) u_bo_cnt (
        .clk(clk), .rst_n(rst_n), .inc(inc_bo), .cnt(backoff_cnt)
    );

    // ---------------- assertions ----------------
    AST_TX_NEEDS_RTS: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en |-> rts); // R5
    AST_RX_OFF_WHILE_KEYED: assert property (@(posedge clk) disable iff (!rst_n)
        rts |-> !rx_en); // R5
    AST_FETCH_ONLY_KEYED: assert property (@(posedge clk) disable iff (!rst_n)
        byte_fetch |-> tx_en); // R6
    AST_DROP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        frame_drop |-> !tx_en && !rts && rx_en); // R10
    AST_CARRIER_HOLDS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_DEFER && !tx_busy && carrier_det |=> st == ST_DEFER && !rts); // R3
    AST_CHAIN_KEEPS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_ENDDLY && tx_fire && frame_pending |=> rts && tx_en && frame_start); // R8
    AST_UNDERRUN_IDLE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        st != ST_SEND |=> !frame_drop); // R11
endmodule

// File: tb/csma_key_ctrl_tb.sv
module csma_key_ctrl_tb;
    localparam int PW = 8;
    localparam int LW = 12;
    localparam int CW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0, frame_pending = 1'b0, carrier_det = 1'b0;
    logic [LW-1:0] frame_len = '0;
    logic [7:0] rand_byte = 8'd0, p_persist = 8'd255;
    logic [PW-1:0] p_txdelay = 8'd2, p_slottime = 8'd3, p_squelch = 8'd3, p_enddelay = 8'd2;
    logic byte_req = 1'b0, underrun = 1'b0;
    logic rts, tx_en, rx_en, frame_start, byte_fetch, frame_done, frame_drop;
    logic [CW-1:0] defer_cnt, backoff_cnt;

    int checks = 0, errors = 0;
    int n_fetch = 0, n_start = 0, n_done = 0, n_drop = 0;

    always #2.5 clk = ~clk;

    csma_key_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .frame_pending(frame_pending),
        .frame_len(frame_len), .carrier_det(carrier_det), .rand_byte(rand_byte),
        .p_persist(p_persist), .p_txdelay(p_txdelay), .p_slottime(p_slottime),
        .p_squelch(p_squelch), .p_enddelay(p_enddelay), .byte_req(byte_req),
        .underrun(underrun), .rts(rts), .tx_en(tx_en), .rx_en(rx_en),
        .frame_start(frame_start), .byte_fetch(byte_fetch), .frame_done(frame_done),
        .frame_drop(frame_drop), .defer_cnt(defer_cnt), .backoff_cnt(backoff_cnt)
    );

    always @(posedge clk) begin
        if (byte_fetch)  n_fetch++;
        if (frame_start) n_start++;
        if (frame_done)  n_done++;
        if (frame_drop)  n_drop++;
    end

    // {carrier, persist, rand, outcome: 0 defer, 1 backoff, 2 key}
    localparam logic [18:0] VEC [7] = '{
        {1'b1, 8'd64,  8'd0,   2'd0},
        {1'b0, 8'd64,  8'd64,  2'd1},
        {1'b0, 8'd64,  8'd63,  2'd2},
        {1'b0, 8'd64,  8'd200, 2'd1},
        {1'b0, 8'd0,   8'd0,   2'd1},
        {1'b0, 8'd255, 8'd254, 2'd2},
        {1'b1, 8'd255, 8'd0,   2'd0}
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick_n(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
    endtask

    task automatic pulse_req();
        @(negedge clk) byte_req = 1'b1;
        @(negedge clk) byte_req = 1'b0;
    endtask

    task automatic pulse_underrun();
        @(negedge clk) underrun = 1'b1;
        @(negedge clk) underrun = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        settle(2);
        rst_n = 1'b1;
        settle(1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        settle(3);
        rst_n = 1'b1;
        settle(1);
        // R1 reset state
        chk("R1 rts", rts, 0);
        chk("R1 tx_en", tx_en, 0);
        chk("R1 rx_en", rx_en, 0);
        chk("R1 defer_cnt", defer_cnt, 0);
        chk("R1 backoff_cnt", backoff_cnt, 0);
        chk("R1 pulses", n_fetch + n_start + n_done + n_drop, 0);

        // R2 squelch delay of 3 ticks
        tick_n(2); settle(2);
        chk("R2 rx_en before squelch end", rx_en, 0);
        tick_n(1); settle(2);
        chk("R2 rx_en at squelch end", rx_en, 1);

        // R3 carrier deferral, R11 stray underrun
        carrier_det = 1'b1; frame_len = 12'd3; frame_pending = 1'b1;
        settle(4);
        chk("R3 defer_cnt first", defer_cnt, 1);
        chk("R3 rts stays low", rts, 0);
        pulse_underrun(); settle(2);
        chk("R11 no drop in defer", n_drop, 0);
        chk("R11 rts unchanged", rts, 0);
        tick_n(9); settle(2);
        chk("R3 no recheck before window", defer_cnt, 1);
        tick_n(1); settle(2);
        chk("R3 recheck after window", defer_cnt, 2);
        carrier_det = 1'b0;
        tick_n(10); settle(3);
        chk("R5 rts on keyup", rts, 1);
        chk("R5 rx_en off on keyup", rx_en, 0);
        chk("R5 tx_en still off", tx_en, 0);
        chk("R4 no backoff when winning", backoff_cnt, 0);

        // R5 keyup wait and tx delay
        tick_n(9); settle(2);
        chk("R5 tx_en before keyup wait", tx_en, 0);
        tick_n(1); settle(2);
        chk("R5 tx_en after keyup wait", tx_en, 1);
        tick_n(1); settle(2);
        chk("R5 no start before txdelay", n_start, 0);
        tick_n(1); settle(2);
        chk("R5 start after txdelay", n_start, 1);
        chk("R5 first fetch with start", n_fetch, 1);
        frame_pending = 1'b0;

        // R6 byte supply, R7 tail, R9 release
        pulse_req(); pulse_req(); settle(2);
        chk("R6 fetch per request", n_fetch, 3);
        pulse_req(); settle(2);
        chk("R6 no fetch past length", n_fetch, 3);
        pulse_underrun(); settle(2);
        chk("R7 expected underrun no drop", n_drop, 0);
        chk("R7 tx_en kept in tail", tx_en, 1);
        pulse_req();
        tick_n(1); settle(2);
        chk("R7 no done before enddelay", n_done, 0);
        tick_n(1); settle(2);
        chk("R7 done after enddelay", n_done, 1);
        chk("R9 tx_en off", tx_en, 0);
        chk("R9 rts off", rts, 0);
        chk("R9 rx_en on", rx_en, 1);

        // R8 chained frame
        frame_len = 12'd1; frame_pending = 1'b1;
        settle(4);
        tick_n(10); tick_n(2); settle(2);
        chk("R8 second frame started", n_start, 2);
        chk("R6 single byte fetched", n_fetch, 4);
        pulse_req(); pulse_req();
        frame_len = 12'd4; carrier_det = 1'b1;
        tick_n(2); settle(2);
        chk("R8 chained start", n_start, 3);
        chk("R8 chained fetch", n_fetch, 5);
        chk("R8 rts held", rts, 1);
        chk("R8 tx_en held", tx_en, 1);
        chk("R8 no defer counted", defer_cnt, 2);
        chk("R8 no backoff counted", backoff_cnt, 0);

        // R10 unexpected underrun
        pulse_req(); settle(1);
        chk("R6 chained byte", n_fetch, 6);
        carrier_det = 1'b0;
        pulse_underrun(); settle(1);
        chk("R10 drop pulse", n_drop, 1);
        chk("R10 tx_en off", tx_en, 0);
        chk("R10 rts off", rts, 0);
        chk("R10 rx_en on", rx_en, 1);
        tick_n(2); settle(3);
        chk("R10 no retry before slot", rts, 0);
        tick_n(1); settle(3);
        chk("R10 retry after slot", rts, 1);
        frame_pending = 1'b0;

        // R3/R4 decision table
        for (int v = 0; v < 7; v++) begin
            do_reset();
            carrier_det = VEC[v][18];
            p_persist   = VEC[v][17:10];
            rand_byte   = VEC[v][9:2];
            frame_pending = 1'b1;
            settle(5);
            chk("R3 table defer", defer_cnt, (VEC[v][1:0] == 2'd0) ? 1 : 0);
            chk("R4 table backoff", backoff_cnt, (VEC[v][1:0] == 2'd1) ? 1 : 0);
            chk("R4 table keyed", rts, (VEC[v][1:0] == 2'd2) ? 1 : 0);
            frame_pending = 1'b0;
        end

        // R12 saturation
        do_reset();
        carrier_det = 1'b0; p_persist = 8'd0; rand_byte = 8'd0; p_slottime = 8'd1;
        frame_pending = 1'b1;
        settle(3);
        tick_n(300); settle(3);
        chk("R12 backoff saturates", backoff_cnt, 255);
        chk("R12 defer untouched", defer_cnt, 0);
        frame_pending = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule